// File: doc/BRIEF.md
# Commit-Time Load Value Replay Checker

This block checks memory ordering by value instead of by address search. Each load that completes out of order is enqueued here in program order. The entry holds the load's tag, its translated address, the data it returned and a safety flag. The oldest entry is then checked in one of two ways. If its safety flag still holds, a filter passes it at once. If not, the block reads the data cache again at the address it already stored, so no address is recomputed. It then compares the new data with the data the load originally returned.

When the two values agree, the load is marked ready and the commit logic may retire it. When they differ, the block raises a squash carrying the tag of the failing load and drops every queued entry. The pipeline then flushes and refetches from that load.

The block has one cache read port, and committing stores use the same port. A store that asks for the port always gets it. While a replay waits for the port, commit stalls, but new loads are still accepted.

Top module: `load_replay_checker`

## Requirements
- R1: After reset the queue is empty. `ld_ready` is 1, and `head_ready`, `cache_rd_en` and `squash_valid` are 0.
- R2: A load is filtered when it was enqueued with `ld_older_st_pend`=0 and no invalidation has matched its address since. Such a load makes no cache read, and `head_ready` rises one cycle after the load becomes the oldest entry.
- R3: A load that is not filtered drives `cache_rd_en`=1 with `cache_rd_addr` equal to the address it was enqueued with. It does this in the first cycle it is oldest and the port is free. The cache returns `cache_rd_data` one cycle after the read.
- R4: `cache_rd_en` is 0 in every cycle in which `st_req` is 1. A replay denied the port waits and retries.
- R5: If the replayed data equals the stored data, `head_ready` rises the cycle after the data returns, and no squash is raised.
- R6: If the replayed data differs from the stored data, `squash_valid` is 1 for exactly one cycle with `squash_tag` equal to the load's tag. All queued entries are discarded, and so is a load presented in the cycle the mismatch is detected.
- R7: An invalidation (`inv_valid`=1) whose address equals that of a queued load clears that load's safety flag, so the load is replayed even though it entered as safe.
- R8: Only the oldest entry is checked. A younger entry never raises `head_ready` before the older entries have committed.
- R9: `commit_load` removes the oldest entry only while `head_ready` is 1, and is ignored otherwise. `head_ready` stays 1 until it is committed.
- R10: When DEPTH entries are held, `ld_ready` is 0 and a presented load is dropped.
- R11: A load presented while the oldest entry waits for the port is accepted, and it is checked after the older one commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Completed load presented, in program order |
| ld_tag | input | TAG_W | Load identifier |
| ld_addr | input | ADDR_W | Translated load address |
| ld_data | input | DATA_W | Value the load obtained |
| ld_older_st_pend | input | 1 | An older store was unresolved when the load executed |
| ld_ready | output | 1 | Queue can take a load |
| inv_valid | input | 1 | External invalidation |
| inv_addr | input | ADDR_W | Invalidated address |
| st_req | input | 1 | A committing store uses the cache port this cycle |
| cache_rd_en | output | 1 | Replay read on the shared port |
| cache_rd_addr | output | ADDR_W | Replay read address |
| cache_rd_data | input | DATA_W | Read data, one cycle after the read |
| head_ready | output | 1 | Oldest load is verified and may commit |
| head_tag | output | TAG_W | Tag of the oldest load |
| commit_load | input | 1 | Commit logic retires the oldest load |
| squash_valid | output | 1 | Value mismatch detected |
| squash_tag | output | TAG_W | Tag of the mismatching load |

## Verification
The hardest situation to reach from the ports is a filter decision changed by an invalidation that lands on a load which is queued but not yet the oldest. The bench holds `st_req` high so that an unsafe older load is stuck waiting for the port. It enqueues a safe load behind it and invalidates that load's address. It then releases the port and checks that the younger load now makes its own cache read. The same port stall is used to fill the queue and to test a commit request that arrives before the oldest load is verified.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

  typedef enum logic [1:0] {
    CK_IDLE = 2'd0,
    CK_WAIT = 2'd1,
    CK_OK   = 2'd2
  } chk_state_e;

endpackage

// File: rtl/lrc_entry_queue.sv
module lrc_entry_queue #(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 6,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_safe,
  input  logic              pop,
  input  logic              flush,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              empty,
  output logic              full,
  output logic [TAG_W-1:0]  head_tag,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic              head_safe
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];

  logic [DEPTH-1:0] safe_q, safe_d, inv_hit;
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // one address comparator per entry for invalidation snooping
  for (genvar i = 0; i < DEPTH; i++) begin : g_snoop
    assign inv_hit[i] = inv_valid && (addr_mem[i] == inv_addr);
  end

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    safe_d = safe_q & ~inv_hit;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
      safe_d = '0;
    end else begin
      if (push) begin
        safe_d[wptr_q] = push_safe;
        wptr_d         = ptr_inc(wptr_q);
      end
      if (pop) begin
        rptr_d = ptr_inc(rptr_q);
      end
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      safe_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      safe_q <= safe_d;
    end
  end

  // payload storage needs no reset: occupancy is tracked by the pointers
  always_ff @(posedge clk) begin
    if (push && !flush) begin
      tag_mem[wptr_q]  <= push_tag;
      addr_mem[wptr_q] <= push_addr;
      data_mem[wptr_q] <= push_data;
    end
  end

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign head_tag  = tag_mem[rptr_q];
  assign head_addr = addr_mem[rptr_q];
  assign head_data = data_mem[rptr_q];
  assign head_safe = safe_q[rptr_q];

endmodule

// File: rtl/lrc_port_arb.sv
module lrc_port_arb #(
  parameter int ADDR_W = 16
) (
  input  logic              st_req,
  input  logic              rep_req,
  input  logic [ADDR_W-1:0] rep_addr,
  output logic              rep_gnt,
  output logic              cache_rd_en,
  output logic [ADDR_W-1:0] cache_rd_addr
);

  // committing stores always win the shared port
  always_comb begin
    rep_gnt       = rep_req && !st_req;
    cache_rd_en   = rep_gnt;
    cache_rd_addr = rep_addr;
  end

endmodule

// File: rtl/lrc_check_ctrl.sv
module lrc_check_ctrl
  import lrc_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_valid,
  input  logic              head_safe,
  input  logic [TAG_W-1:0]  head_tag,
  input  logic [DATA_W-1:0] head_data,
  input  logic              rep_gnt,
  input  logic [DATA_W-1:0] cache_rd_data,
  input  logic              commit_load,
  output logic              rep_req,
  output logic              pop,
  output logic              flush,
  output logic              head_ready,
  output logic              squash_valid,
  output logic [TAG_W-1:0]  squash_tag
);

  chk_state_e       state_q, state_d;
  logic             sq_vld_d;
  logic [TAG_W-1:0] sq_tag_d;

  always_comb begin
    state_d  = state_q;
    rep_req  = 1'b0;
    pop      = 1'b0;
    flush    = 1'b0;
    sq_vld_d = 1'b0;
    sq_tag_d = squash_tag;
    case (state_q)
      CK_IDLE: begin
        if (head_valid) begin
          if (head_safe) begin
            state_d = CK_OK;
          end else begin
            rep_req = 1'b1;
            if (rep_gnt) state_d = CK_WAIT;
          end
        end
      end
      CK_WAIT: begin
        if (cache_rd_data == head_data) begin
          state_d = CK_OK;
        end else begin
          flush    = 1'b1;
          sq_vld_d = 1'b1;
          sq_tag_d = head_tag;
          state_d  = CK_IDLE;
        end
      end
      CK_OK: begin
        if (commit_load) begin
          pop     = 1'b1;
          state_d = CK_IDLE;
        end
      end
      default: state_d = CK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= CK_IDLE;
      squash_valid <= 1'b0;
      squash_tag   <= '0;
    end else begin
      state_q      <= state_d;
      squash_valid <= sq_vld_d;
      squash_tag   <= sq_tag_d;
    end
  end

  assign head_ready = (state_q == CK_OK);

endmodule

// File: rtl/load_replay_checker.sv
module load_replay_checker #(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 6,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_older_st_pend,
  output logic              ld_ready,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic              st_req,
  output logic              cache_rd_en,
  output logic [ADDR_W-1:0] cache_rd_addr,
  input  logic [DATA_W-1:0] cache_rd_data,
  output logic              head_ready,
  output logic [TAG_W-1:0]  head_tag,
  input  logic              commit_load,
  output logic              squash_valid,
  output logic [TAG_W-1:0]  squash_tag
);

  logic              q_empty, q_full, q_push, q_pop, q_flush, q_safe_in;
  logic              h_safe, rep_req, rep_gnt;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_data;

  assign ld_ready  = !q_full;
  assign q_push    = ld_valid && !q_full && !q_flush;
  assign q_safe_in = !ld_older_st_pend && !(inv_valid && (inv_addr == ld_addr));

  lrc_entry_queue #(
    .DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(q_push), .push_tag(ld_tag), .push_addr(ld_addr),
    .push_data(ld_data), .push_safe(q_safe_in),
    .pop(q_pop), .flush(q_flush),
    .inv_valid(inv_valid), .inv_addr(inv_addr),
    .empty(q_empty), .full(q_full),
    .head_tag(head_tag), .head_addr(h_addr),
    .head_data(h_data), .head_safe(h_safe)
  );

  lrc_port_arb #(.ADDR_W(ADDR_W)) u_arb (
    .st_req(st_req), .rep_req(rep_req), .rep_addr(h_addr),
    .rep_gnt(rep_gnt), .cache_rd_en(cache_rd_en),
    .cache_rd_addr(cache_rd_addr)
  );

  lrc_check_ctrl #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .head_valid(!q_empty), .head_safe(h_safe),
    .head_tag(head_tag), .head_data(h_data),
    .rep_gnt(rep_gnt), .cache_rd_data(cache_rd_data),
    .commit_load(commit_load),
    .rep_req(rep_req), .pop(q_pop), .flush(q_flush),
    .head_ready(head_ready),
    .squash_valid(squash_valid), .squash_tag(squash_tag)
  );

endmodule

// File: rtl/lrc_sva.sv
module lrc_sva (
  input logic clk,
  input logic rst_n,
  input logic st_req,
  input logic cache_rd_en,
  input logic head_ready,
  input logic commit_load,
  input logic squash_valid,
  input logic ld_ready
);

  // R4: a committing store owns the port
  p_store_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_req |-> !cache_rd_en);

  // R3: one replay at a time, the next cycle waits for data
  p_single_replay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cache_rd_en |=> !cache_rd_en && !head_ready);

  // R6: squash is a single-cycle pulse
  p_squash_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> !squash_valid);

  // R6: after a squash the queue is empty
  p_squash_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |-> ld_ready && !head_ready);

  // R9: a verified load waits for its commit
  p_ready_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    head_ready && !commit_load |=> head_ready);

  // R5: a verified load raises no squash alongside
  p_ready_no_squash_r5: assert property (@(posedge clk) disable iff (!rst_n)
    head_ready |-> !squash_valid);

endmodule

bind load_replay_checker lrc_sva u_lrc_sva (
  .clk(clk), .rst_n(rst_n), .st_req(st_req), .cache_rd_en(cache_rd_en),
  .head_ready(head_ready), .commit_load(commit_load),
  .squash_valid(squash_valid), .ld_ready(ld_ready)
);

// File: tb/load_replay_checker_test.sv
module load_replay_checker_test;

  localparam int DEPTH  = 4;
  localparam int TAG_W  = 6;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ld_valid, ld_older_st_pend, inv_valid, st_req, commit_load;
  logic [TAG_W-1:0]  ld_tag;
  logic [ADDR_W-1:0] ld_addr, inv_addr;
  logic [DATA_W-1:0] ld_data;
  logic              ld_ready, cache_rd_en, head_ready, squash_valid;
  logic [ADDR_W-1:0] cache_rd_addr;
  logic [DATA_W-1:0] cache_rd_data;
  logic [TAG_W-1:0]  head_tag, squash_tag;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  load_replay_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_tag(ld_tag),
    .ld_addr(ld_addr), .ld_data(ld_data), .ld_older_st_pend(ld_older_st_pend),
    .ld_ready(ld_ready), .inv_valid(inv_valid), .inv_addr(inv_addr),
    .st_req(st_req), .cache_rd_en(cache_rd_en), .cache_rd_addr(cache_rd_addr),
    .cache_rd_data(cache_rd_data), .head_ready(head_ready), .head_tag(head_tag),
    .commit_load(commit_load), .squash_valid(squash_valid), .squash_tag(squash_tag)
  );

  // cache model: fixed contents, one cycle read latency
  function automatic logic [DATA_W-1:0] mem_val(input logic [ADDR_W-1:0] a);
    return {16'hC0DE, a};
  endfunction

  always_ff @(posedge clk) begin
    if (cache_rd_en) cache_rd_data <= mem_val(cache_rd_addr);
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic drive_ld(input int tag, input int addr, input logic bad, input logic pend);
    ld_valid         = 1'b1;
    ld_tag           = TAG_W'(tag);
    ld_addr          = ADDR_W'(addr);
    ld_data          = bad ? ~mem_val(ADDR_W'(addr)) : mem_val(ADDR_W'(addr));
    ld_older_st_pend = pend;
  endtask

  task automatic wait_ready(input string what);
    int n = 0;
    while (!head_ready && n < 12) begin
      step();
      n++;
    end
    chk(what, 64'(head_ready), 64'd1);
  endtask

  task automatic do_commit();
    commit_load = 1'b1;
    step();
    commit_load = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ld_ready", 64'(ld_ready), 64'd1);
    chk("R1 head_ready", 64'(head_ready), 64'd0);
    chk("R1 cache_rd_en", 64'(cache_rd_en), 64'd0);
    chk("R1 squash_valid", 64'(squash_valid), 64'd0);
  endtask

  task automatic t_filter();
    step(); drive_ld(1, 2, 1'b0, 1'b0);
    step(); ld_valid = 1'b0;
    chk("R2 no replay read", 64'(cache_rd_en), 64'd0);
    chk("R2 not yet ready", 64'(head_ready), 64'd0);
    step();
    chk("R2 ready", 64'(head_ready), 64'd1);
    chk("R2 tag", 64'(head_tag), 64'd1);
    do_commit();
    chk("R9 popped", 64'(head_ready), 64'd0);
  endtask

  task automatic t_replay_match();
    step(); drive_ld(2, 3, 1'b0, 1'b1);
    step(); ld_valid = 1'b0;
    chk("R3 read issued", 64'(cache_rd_en), 64'd1);
    chk("R3 stored address", 64'(cache_rd_addr), 64'd3);
    step();
    chk("R3 waiting", 64'(cache_rd_en), 64'd0);
    chk("R5 not ready while waiting", 64'(head_ready), 64'd0);
    step();
    chk("R5 ready after match", 64'(head_ready), 64'd1);
    chk("R5 tag", 64'(head_tag), 64'd2);
    chk("R5 no squash", 64'(squash_valid), 64'd0);
    do_commit();
  endtask

  task automatic t_mismatch();
    step(); drive_ld(3, 4, 1'b1, 1'b1);
    step(); drive_ld(4, 1, 1'b0, 1'b0);
    chk("R3 read on mismatch path", 64'(cache_rd_en), 64'd1);
    step(); drive_ld(5, 6, 1'b0, 1'b0);
    step(); ld_valid = 1'b0;
    chk("R6 squash raised", 64'(squash_valid), 64'd1);
    chk("R6 squash tag", 64'(squash_tag), 64'd3);
    chk("R6 ld_ready", 64'(ld_ready), 64'd1);
    step();
    chk("R6 squash one cycle", 64'(squash_valid), 64'd0);
    step(); step();
    chk("R6 younger discarded", 64'(head_ready), 64'd0);
    chk("R6 no replay of discarded", 64'(cache_rd_en), 64'd0);
  endtask

  task automatic t_store_block();
    step(); st_req = 1'b1; drive_ld(6, 6, 1'b0, 1'b1);
    step(); drive_ld(7, 7, 1'b0, 1'b0);
    chk("R4 port held by store", 64'(cache_rd_en), 64'd0);
    step(); ld_valid = 1'b0; commit_load = 1'b1;
    chk("R4 still held", 64'(cache_rd_en), 64'd0);
    chk("R11 ld_ready during stall", 64'(ld_ready), 64'd1);
    chk("R8 younger safe not ready", 64'(head_ready), 64'd0);
    step(); commit_load = 1'b0; st_req = 1'b0; #1;
    chk("R4 replay after release", 64'(cache_rd_en), 64'd1);
    chk("R9 early commit ignored", 64'(cache_rd_addr), 64'd6);
    step(); step();
    chk("R9 ready", 64'(head_ready), 64'd1);
    chk("R9 head is first load", 64'(head_tag), 64'd6);
    do_commit();
    chk("R8 next needs a cycle", 64'(head_ready), 64'd0);
    step();
    chk("R11 accepted load ready", 64'(head_ready), 64'd1);
    chk("R11 tag", 64'(head_tag), 64'd7);
    do_commit();
  endtask

  task automatic t_inv();
    step(); st_req = 1'b1; drive_ld(8, 8, 1'b0, 1'b1);
    step(); drive_ld(9, 5, 1'b0, 1'b0);
    step(); ld_valid = 1'b0; inv_valid = 1'b1; inv_addr = 16'd5;
    step(); inv_valid = 1'b0; st_req = 1'b0; #1;
    chk("R7 older replays first", 64'(cache_rd_addr), 64'd8);
    step(); step();
    chk("R7 older verified", 64'(head_tag), 64'd8);
    do_commit();
    chk("R7 invalidated load replays", 64'(cache_rd_en), 64'd1);
    chk("R7 replay address", 64'(cache_rd_addr), 64'd5);
    step(); step();
    chk("R7 ready after replay", 64'(head_ready), 64'd1);
    chk("R7 tag", 64'(head_tag), 64'd9);
    do_commit();
  endtask

  task automatic t_full();
    st_req = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      step(); drive_ld(16 + i, 10 + i, 1'b0, (i == 0));
    end
    step(); drive_ld(31, 20, 1'b0, 1'b0);
    chk("R10 ld_ready low when full", 64'(ld_ready), 64'd0);
    step(); ld_valid = 1'b0; st_req = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      wait_ready("R10 drain ready");
      chk("R10 drain order", 64'(head_tag), 64'(16 + k));
      do_commit();
    end
    step(); step(); step();
    chk("R10 extra load dropped", 64'(head_ready), 64'd0);
    chk("R10 queue empty", 64'(ld_ready), 64'd1);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ld_valid = 1'b0; ld_tag = '0; ld_addr = '0; ld_data = '0;
    ld_older_st_pend = 1'b0; inv_valid = 1'b0; inv_addr = '0;
    st_req = 1'b0; commit_load = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_filter();
    t_replay_match();
    t_mismatch();
    t_store_block();
    t_inv();
    t_full();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule